// File: doc/BRIEF.md
# USB Device Interrupt Event Aggregator

This block forms the top level of the interrupt tree in a USB device controller. It merges summary lines from the lower-level event registers (transmit, receive, NAK, DMA and wake-up) with event bits of its own. Its own bits are set by pulses from the frame timer and the bus state machine. The result is a main status byte and an alternate status byte. Each byte has a mask byte with the same layout. The block drives a single registered interrupt line.

Different bits clear in different ways. Transmit, receive and DMA summaries stay set until every lower-level flag behind them has gone low. The NAK summary clears only when the NAK event register is read, which the block sees as a strobe. The frame and lock-change bits, and the bus-condition bits of the alternate byte, clear when their own byte is read. Wake-up follows its pending sources. The top bit position of the main status byte always reads 0. The same position in the mask byte is the global interrupt enable.

A CPU reads and writes the four byte registers through a small address/strobe port. Read data is combinational.

Top module: `usb_irq_rollup`

## Requirements
- R1: Main bit 1 (transmit) becomes 1 one clock after any `tx_flag_i` bit is 1 together with its `tx_msk_i` bit. It then stays 1 while any `tx_flag_i` bit is 1, whether masked or not, and becomes 0 one clock after all `tx_flag_i` bits are 0.
- R2: Main bit 2 (receive) behaves the same way as R1, driven by `rx_flag_i` and `rx_msk_i`.
- R3: Alternate bit 2 (DMA) behaves the same way as R1, driven by `dma_flag_i` and `dma_msk_i`. It is read-only, and reading the alternate byte does not clear it.
- R4: Main bit 3 (NAK) becomes 1 one clock after a `nak_pulse_i` bit is pulsed while its `nak_msk_i` bit is 1. A `nak_clr_i` strobe clears it. A read of the main byte does not clear it.
- R5: Main bit 4 (frame) becomes 1 one clock after a `frame_load_i` pulse. A read of address 0 (`cpu_rd_i`=1) clears it at that clock edge. Reads of other addresses leave it unchanged.
- R6: Main bit 5 (lock change) becomes 1 one clock after `frame_locked_i` differs from its value at the previous clock edge. The stored previous value resets to 0. A read of address 0 clears the bit.
- R7: Alternate bits 3..7 are set by `alt_pulse_i[0..4]`: bit 3 end-of-packet, bit 4 3 ms suspend, bit 5 5 ms suspend, bit 6 bus reset, bit 7 resume. A read of address 2 clears them all.
- R8: If a clear-on-read bit gets a set pulse in the same cycle that its byte is read, the bit is 1 after that clock edge.
- R9: Alternate bit 1 (wake-up) is the OR of `wk_pend_i`, registered one clock. It is read-only, and reads do not clear it.
- R10: Main bit 0 is 1 whenever (alternate status AND alternate mask) is nonzero. Main bits 6 and 7 and alternate bit 0 always read 0.
- R11: The main mask (address 1) and the alternate mask (address 3) can be read and written and reset to 0. Writes to addresses 0 and 2 change nothing.
- R12: `irq_o` is 1 one clock after main mask bit 7 is 1 and (main status bits 6..0 AND main mask bits 6..0) is nonzero. Otherwise it is 0 one clock later.
- R13: After reset, every status byte, every mask byte and `irq_o` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr_i | input | 2 | Register address: 0 main status, 1 main mask, 2 alt status, 3 alt mask |
| cpu_wr_i | input | 1 | Write strobe |
| cpu_rd_i | input | 1 | Read strobe (triggers clear-on-read) |
| cpu_wdata_i | input | 8 | Write data |
| cpu_rdata_o | output | 8 | Read data for the addressed register |
| tx_flag_i | input | N_TX | Lower-level transmit done/underrun flags |
| tx_msk_i | input | N_TX | Lower-level transmit event mask |
| rx_flag_i | input | N_RX | Lower-level receive last/overrun flags |
| rx_msk_i | input | N_RX | Lower-level receive event mask |
| nak_pulse_i | input | N_NAK | NAK event pulses |
| nak_msk_i | input | N_NAK | NAK event mask |
| nak_clr_i | input | 1 | Strobe: NAK event register was read |
| dma_flag_i | input | N_DMA | Lower-level DMA event flags |
| dma_msk_i | input | N_DMA | DMA event mask |
| wk_pend_i | input | 2 | Wake-up pending sources |
| frame_load_i | input | 1 | Pulse: frame counter loaded |
| frame_locked_i | input | 1 | Frame timer lock state |
| alt_pulse_i | input | 5 | Bus condition pulses (see R7) |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The assertions check on every cycle the rules each bit must follow. Sticky summaries rise after an unmasked flag, hold while flags remain, and drop once the flags are gone. Clear-on-read bits keep a set that arrives together with a read and empty on a read with no set. Wake-up follows its sources, and the interrupt never rises without the enable from the cycle before. Only the bench scenarios can show how these combine. Those are the exact bit positions and addresses, the one-clock lag between status and interrupt, that a read of one byte leaves the other byte alone, and that a mask withdrawn after the set does not drop a sticky summary.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;

    localparam int ADDR_W = 2;
    localparam int DATA_W = 8;

    localparam logic [ADDR_W-1:0] A_MAIN_STAT = 2'd0;
    localparam logic [ADDR_W-1:0] A_MAIN_MASK = 2'd1;
    localparam logic [ADDR_W-1:0] A_ALT_STAT  = 2'd2;
    localparam logic [ADDR_W-1:0] A_ALT_MASK  = 2'd3;

    localparam int ALT_COR_W = 5;
    localparam int WK_W      = 2;
    localparam int EN_BIT    = 7;

    typedef struct packed {
        logic [DATA_W-1:0] main_mask;
        logic [DATA_W-1:0] alt_mask;
        logic              lock_prev;
        logic              wk;
        logic              irq;
    } rollup_state_t;

endpackage

// File: rtl/usb_irq_sticky_sum.sv
module usb_irq_sticky_sum #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] flag_i,
    input  logic [W-1:0] msk_i,
    output logic         sum_o
);
    typedef struct packed {
        logic sum;
    } sum_state_t;

    sum_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        // rises on an unmasked flag, holds while any flag remains at all
        st_d.sum = (|(flag_i & msk_i)) | (st_q.sum & (|flag_i));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sum_o = st_q.sum;

    AST_SUM_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (|(flag_i & msk_i)) |=> sum_o); // R1
    AST_SUM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (sum_o && (|flag_i)) |=> sum_o); // R2
    AST_SUM_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_i == '0) |=> !sum_o); // R3

endmodule

// File: rtl/usb_irq_cor_bits.sv
module usb_irq_cor_bits #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic         clr_i,
    output logic [W-1:0] q_o
);
    typedef struct packed {
        logic [W-1:0] q;
    } cor_state_t;

    cor_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) st_d.q = '0;
        // a set in the clearing cycle wins, so no event is dropped
        st_d.q = st_d.q | set_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q_o = st_q.q;

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((q_o & $past(set_i)) == $past(set_i))); // R8
    AST_READ_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && (set_i == '0)) |=> (q_o == '0)); // R7

endmodule

// File: rtl/usb_irq_rollup.sv
module usb_irq_rollup
    import usb_irq_pkg::*;
#(
    parameter int N_TX  = 4,
    parameter int N_RX  = 4,
    parameter int N_NAK = 8,
    parameter int N_DMA = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cpu_addr_i,
    input  logic              cpu_wr_i,
    input  logic              cpu_rd_i,
    input  logic [DATA_W-1:0] cpu_wdata_i,
    output logic [DATA_W-1:0] cpu_rdata_o,
    input  logic [N_TX-1:0]   tx_flag_i,
    input  logic [N_TX-1:0]   tx_msk_i,
    input  logic [N_RX-1:0]   rx_flag_i,
    input  logic [N_RX-1:0]   rx_msk_i,
    input  logic [N_NAK-1:0]  nak_pulse_i,
    input  logic [N_NAK-1:0]  nak_msk_i,
    input  logic              nak_clr_i,
    input  logic [N_DMA-1:0]  dma_flag_i,
    input  logic [N_DMA-1:0]  dma_msk_i,
    input  logic [WK_W-1:0]   wk_pend_i,
    input  logic              frame_load_i,
    input  logic              frame_locked_i,
    input  logic [ALT_COR_W-1:0] alt_pulse_i,
    output logic              irq_o
);
    localparam int MAIN_COR_W = 2;

    logic tx_sum, rx_sum, dma_sum, nak_bit;
    logic [MAIN_COR_W-1:0] main_cor;   // [0] frame, [1] lock change
    logic [ALT_COR_W-1:0]  alt_cor;
    logic [DATA_W-1:0]     main_stat, alt_stat;
    logic                  rd_main, rd_alt, lock_edge;

    rollup_state_t st_d, st_q;

    assign rd_main   = cpu_rd_i && (cpu_addr_i == A_MAIN_STAT);
    assign rd_alt    = cpu_rd_i && (cpu_addr_i == A_ALT_STAT);
    assign lock_edge = frame_locked_i ^ st_q.lock_prev;

    usb_irq_sticky_sum #(.W(N_TX)) u_tx (
        .clk(clk), .rst_n(rst_n), .flag_i(tx_flag_i), .msk_i(tx_msk_i), .sum_o(tx_sum));
    usb_irq_sticky_sum #(.W(N_RX)) u_rx (
        .clk(clk), .rst_n(rst_n), .flag_i(rx_flag_i), .msk_i(rx_msk_i), .sum_o(rx_sum));
    usb_irq_sticky_sum #(.W(N_DMA)) u_dma (
        .clk(clk), .rst_n(rst_n), .flag_i(dma_flag_i), .msk_i(dma_msk_i), .sum_o(dma_sum));

    usb_irq_cor_bits #(.W(1)) u_nak (
        .clk(clk), .rst_n(rst_n), .set_i(|(nak_pulse_i & nak_msk_i)),
        .clr_i(nak_clr_i), .q_o(nak_bit));
    usb_irq_cor_bits #(.W(MAIN_COR_W)) u_main_cor (
        .clk(clk), .rst_n(rst_n), .set_i({lock_edge, frame_load_i}),
        .clr_i(rd_main), .q_o(main_cor));
    usb_irq_cor_bits #(.W(ALT_COR_W)) u_alt_cor (
        .clk(clk), .rst_n(rst_n), .set_i(alt_pulse_i),
        .clr_i(rd_alt), .q_o(alt_cor));

    always_comb begin
        alt_stat  = {alt_cor, dma_sum, st_q.wk, 1'b0};
        main_stat = {1'b0, 1'b0, main_cor[1], main_cor[0], nak_bit,
                     rx_sum, tx_sum, |(alt_stat & st_q.alt_mask)};
        unique case (cpu_addr_i)
            A_MAIN_STAT: cpu_rdata_o = main_stat;
            A_MAIN_MASK: cpu_rdata_o = st_q.main_mask;
            A_ALT_STAT:  cpu_rdata_o = alt_stat;
            default:     cpu_rdata_o = st_q.alt_mask;
        endcase
    end

    always_comb begin
        st_d           = st_q;
        st_d.lock_prev = frame_locked_i;
        st_d.wk        = |wk_pend_i;
        if (cpu_wr_i && (cpu_addr_i == A_MAIN_MASK)) st_d.main_mask = cpu_wdata_i;
        if (cpu_wr_i && (cpu_addr_i == A_ALT_MASK))  st_d.alt_mask  = cpu_wdata_i;
        st_d.irq = st_q.main_mask[EN_BIT] &
                   (|(main_stat[EN_BIT-1:0] & st_q.main_mask[EN_BIT-1:0]));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_o = st_q.irq;

    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(st_q.main_mask[EN_BIT])); // R12
    AST_IRQ_OFF_NO_EN: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.main_mask[EN_BIT] |=> !irq_o); // R12
    AST_WK_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (|wk_pend_i) |=> alt_stat[1]); // R9

endmodule

// File: tb/usb_irq_rollup_tb.sv
module usb_irq_rollup_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] cpu_addr = '0;
    logic cpu_wr = 1'b0, cpu_rd = 1'b0;
    logic [7:0] cpu_wdata = '0;
    logic [7:0] cpu_rdata;
    logic [3:0] tx_flag = '0, tx_msk = '0, rx_flag = '0, rx_msk = '0;
    logic [7:0] nak_pulse = '0, nak_msk = '0;
    logic nak_clr = 1'b0;
    logic [3:0] dma_flag = '0, dma_msk = '0;
    logic [1:0] wk_pend = '0;
    logic frame_load = 1'b0, frame_locked = 1'b0;
    logic [4:0] alt_pulse = '0;
    logic irq;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    usb_irq_rollup dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_addr_i(cpu_addr), .cpu_wr_i(cpu_wr),
        .cpu_rd_i(cpu_rd), .cpu_wdata_i(cpu_wdata), .cpu_rdata_o(cpu_rdata),
        .tx_flag_i(tx_flag), .tx_msk_i(tx_msk), .rx_flag_i(rx_flag), .rx_msk_i(rx_msk),
        .nak_pulse_i(nak_pulse), .nak_msk_i(nak_msk), .nak_clr_i(nak_clr),
        .dma_flag_i(dma_flag), .dma_msk_i(dma_msk), .wk_pend_i(wk_pend),
        .frame_load_i(frame_load), .frame_locked_i(frame_locked),
        .alt_pulse_i(alt_pulse), .irq_o(irq));

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic peek(input logic [1:0] a, output logic [7:0] d);
        cpu_addr = a;
        #1 d = cpu_rdata;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_rd = 1'b1;
        #1 d = cpu_rdata;
        @(negedge clk);
        cpu_rd = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] v);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = v; cpu_wr = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic t_reset;
        logic [7:0] d;
        for (int a = 0; a < 4; a++) begin
            peek(a[1:0], d);
            chk("R13 reg after reset", d, 8'h00);
        end
        chk("R13 irq after reset", {7'b0, irq}, 8'h00);
    endtask

    task automatic t_tx;
        logic [7:0] d;
        @(negedge clk); tx_flag = 4'b0001; tx_msk = 4'b0000;
        @(negedge clk); peek(0, d); chk("R1 masked flag no set", d & 8'h02, 8'h00);
        tx_msk = 4'b0001;
        @(negedge clk); peek(0, d); chk("R1 unmasked flag sets", d & 8'h02, 8'h02);
        tx_msk = 4'b0000; tx_flag = 4'b1000;
        @(negedge clk); peek(0, d); chk("R1 held by masked flag", d & 8'h02, 8'h02);
        tx_flag = 4'b0000;
        @(negedge clk); peek(0, d); chk("R1 clears when flags low", d & 8'h02, 8'h00);
    endtask

    task automatic t_rx;
        logic [7:0] d;
        @(negedge clk); rx_flag = 4'b0110; rx_msk = 4'b0100;
        @(negedge clk); peek(0, d); chk("R2 rx sets", d & 8'h04, 8'h04);
        rx_flag = 4'b0010;
        @(negedge clk); peek(0, d); chk("R2 rx holds", d & 8'h04, 8'h04);
        rx_flag = 4'b0000; rx_msk = 4'b0000;
        @(negedge clk); peek(0, d); chk("R2 rx clears", d & 8'h04, 8'h00);
    endtask

    task automatic t_dma;
        logic [7:0] d;
        @(negedge clk); dma_flag = 4'b0100; dma_msk = 4'b0100;
        @(negedge clk); peek(2, d); chk("R3 dma sets", d & 8'h04, 8'h04);
        rd(2, d);
        peek(2, d); chk("R3 dma survives alt read", d & 8'h04, 8'h04);
        dma_flag = 4'b0000;
        @(negedge clk); peek(2, d); chk("R3 dma clears", d & 8'h04, 8'h00);
        dma_msk = '0;
    endtask

    task automatic t_nak;
        logic [7:0] d;
        @(negedge clk); nak_msk = 8'h10; nak_pulse = 8'h01;
        @(negedge clk); nak_pulse = 8'h00; peek(0, d); chk("R4 masked nak ignored", d & 8'h08, 8'h00);
        nak_pulse = 8'h10;
        @(negedge clk); nak_pulse = 8'h00; peek(0, d); chk("R4 nak sets", d & 8'h08, 8'h08);
        rd(0, d);
        peek(0, d); chk("R4 main read keeps nak", d & 8'h08, 8'h08);
        nak_clr = 1'b1;
        @(negedge clk); nak_clr = 1'b0; peek(0, d); chk("R4 nak_clr clears", d & 8'h08, 8'h00);
        nak_msk = '0;
    endtask

    task automatic t_frame;
        logic [7:0] d;
        @(negedge clk); frame_load = 1'b1;
        @(negedge clk); frame_load = 1'b0; peek(0, d); chk("R5 frame sets", d & 8'h10, 8'h10);
        rd(1, d); rd(2, d);
        peek(0, d); chk("R5 other reads keep frame", d & 8'h10, 8'h10);
        rd(0, d); chk("R5 read returns frame", d & 8'h10, 8'h10);
        peek(0, d); chk("R5 main read clears frame", d & 8'h10, 8'h00);
    endtask

    task automatic t_lock;
        logic [7:0] d;
        @(negedge clk); frame_locked = 1'b1;
        @(negedge clk); peek(0, d); chk("R6 lock gained", d & 8'h20, 8'h20);
        rd(0, d);
        peek(0, d); chk("R6 read clears lock chg", d & 8'h20, 8'h00);
        frame_locked = 1'b0;
        @(negedge clk); peek(0, d); chk("R6 lock lost", d & 8'h20, 8'h20);
        rd(0, d);
    endtask

    task automatic t_alt;
        logic [7:0] d;
        @(negedge clk); alt_pulse = 5'b10101;
        @(negedge clk); alt_pulse = '0; peek(2, d); chk("R7 alt bits 7,5,3", d, 8'hA8);
        rd(0, d);
        peek(2, d); chk("R7 main read keeps alt", d, 8'hA8);
        @(negedge clk); alt_pulse = 5'b01010;
        @(negedge clk); alt_pulse = '0; peek(2, d); chk("R7 alt bits all", d, 8'hF8);
        rd(2, d); chk("R7 read value", d, 8'hF8);
        peek(2, d); chk("R7 alt read clears", d, 8'h00);
    endtask

    task automatic t_race;
        logic [7:0] d;
        @(negedge clk); frame_load = 1'b1;
        @(negedge clk); frame_load = 1'b1; cpu_addr = 0; cpu_rd = 1'b1;
        alt_pulse = 5'b00001;
        @(negedge clk); frame_load = 1'b0; cpu_rd = 1'b0; alt_pulse = '0;
        peek(0, d); chk("R8 frame kept on read race", d & 8'h10, 8'h10);
        @(negedge clk); cpu_addr = 2; cpu_rd = 1'b1; alt_pulse = 5'b00001;
        @(negedge clk); cpu_rd = 1'b0; alt_pulse = '0;
        peek(2, d); chk("R8 alt kept on read race", d & 8'h08, 8'h08);
        rd(0, d); rd(2, d);
    endtask

    task automatic t_wake;
        logic [7:0] d;
        @(negedge clk); wk_pend = 2'b10;
        @(negedge clk); peek(2, d); chk("R9 wake set", d & 8'h02, 8'h02);
        rd(2, d);
        peek(2, d); chk("R9 wake not cleared by read", d & 8'h02, 8'h02);
        wk_pend = 2'b00;
        @(negedge clk); peek(2, d); chk("R9 wake follows pend", d & 8'h02, 8'h00);
    endtask

    task automatic t_masks;
        logic [7:0] d;
        wr(1, 8'h25); peek(1, d); chk("R11 main mask rw", d, 8'h25);
        wr(3, 8'h5A); peek(3, d); chk("R11 alt mask rw", d, 8'h5A);
        wr(0, 8'hFF); peek(0, d); chk("R11 main stat not writable", d, 8'h00);
        wr(2, 8'hFF); peek(2, d); chk("R11 alt stat not writable", d, 8'h00);
        wr(3, 8'h0A);
        @(negedge clk); wk_pend = 2'b01;
        @(negedge clk); peek(0, d); chk("R10 alt summary in main bit0", d, 8'h01);
        wk_pend = 2'b00;
        @(negedge clk); peek(0, d); chk("R10 alt summary drops", d, 8'h00);
        @(negedge clk); frame_load = 1'b1; frame_locked = 1'b1;
        @(negedge clk); frame_load = 1'b0; frame_locked = 1'b0;
        @(negedge clk); peek(0, d); chk("R10 top bits read 0", d & 8'hC0, 8'h00);
        peek(2, d); chk("R10 alt bit0 reads 0", d & 8'h01, 8'h00);
        rd(0, d);
        wr(1, 8'h00); wr(3, 8'h00);
    endtask

    task automatic t_irq;
        logic [7:0] d;
        wr(1, 8'h82);
        @(negedge clk); tx_flag = 4'b0010; tx_msk = 4'b0010;
        @(negedge clk); chk("R12 irq lags status", {7'b0, irq}, 8'h00);
        @(negedge clk); chk("R12 irq asserted", {7'b0, irq}, 8'h01);
        wr(1, 8'h02);
        @(negedge clk); chk("R12 irq off without enable", {7'b0, irq}, 8'h00);
        wr(1, 8'h84);
        @(negedge clk); chk("R12 irq off when bit unmasked absent", {7'b0, irq}, 8'h00);
        wr(1, 8'h82);
        @(negedge clk); chk("R12 irq back on", {7'b0, irq}, 8'h01);
        tx_flag = '0; tx_msk = '0;
        @(negedge clk); @(negedge clk); chk("R12 irq drops with status", {7'b0, irq}, 8'h00);
        peek(0, d);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_tx(); t_rx(); t_dma(); t_nak(); t_frame(); t_lock();
        t_alt(); t_race(); t_wake(); t_masks(); t_irq();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule